// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character of 5 to 8 data bits into an asynchronous serial frame. The frame is a low start bit, the data bits least significant first, an optional parity bit, and a high stop period of one, one and a half or two bit times. An external divider supplies a one-cycle baud tick at each bit boundary and a half-baud tick at each mid-bit point. The block moves to the next bit only on a baud tick. The final half bit of a one-and-a-half stop period ends on the next half-baud tick.

The link is half-duplex. The block therefore holds a send-permit output low from the cycle after a character is accepted until its last stop period ends, so the far end holds off its own traffic. The character, its length, the parity mode and the stop length are all sampled on the accepting load strobe. A load strobe seen while a frame is in progress is ignored.

The controller is one state machine:
- IDLE goes to START on load.
- START goes to DATA on a baud tick.
- DATA stays in DATA on a baud tick until the last data bit. On that tick it goes to PARITY when parity is enabled, and to STOP1 otherwise.
- PARITY goes to STOP1 on a baud tick.
- STOP1, on a baud tick, goes to IDLE for one stop bit, to STOPH for one and a half, and to STOP2 for two.
- STOP2 goes to IDLE on a baud tick.
- STOPH goes to IDLE on a half-baud tick.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `send_ok` is 1.
- R2: A `load` pulse while idle starts a frame. From the next cycle `txd` is 0 (start bit), `busy` is 1 and `send_ok` is 0. The start bit holds until a `baud_tick` is seen.
- R3: The data bit count is `len_sel`+5 (`len_sel` 0..3 gives 5..8). The bits go out least significant first, each lasting until the next `baud_tick`. Byte 0x55 with 8 bits, no parity and one stop bit gives the line sequence 0,1,0,1,0,1,0,1,0,1.
- R4: `par_mode` selects the parity bit. Code 1 is even: the bit is 1 when the data bits hold an odd count of ones. Code 2 is odd: the bit is 1 when the count is even. Code 3 always sends 1 and code 4 always sends 0. Codes 0, 5, 6 and 7 send no parity bit. Only the `len_sel`+5 sent bits are counted.
- R5: `stop_sel` sets the stop period, during which `txd` is 1. Code 0 is one baud period. Code 1 is one baud period followed by a wait for the next `half_tick`. Codes 2 and 3 are two baud periods.
- R6: A `load` pulse while `busy` is 1 is ignored. The frame in progress continues with its original bits.
- R7: `busy` stays 1 and `send_ok` stays 0 until the last stop period ends. On that same edge `busy` falls and `send_ok` rises.
- R8: `half_tick` has no effect outside the final half-bit stop state.
- R9: `din`, `len_sel`, `par_mode` and `stop_sel` are sampled only on the accepting `load`. Changing them during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 8 | Character to send; unused upper bits ignored |
| load | input | 1 | Start strobe, one cycle |
| baud_tick | input | 1 | One-cycle pulse at each bit boundary |
| half_tick | input | 1 | One-cycle pulse at each mid-bit point |
| len_sel | input | 2 | Data length code, length = code + 5 |
| par_mode | input | 3 | Parity code (see R4) |
| stop_sel | input | 2 | Stop length code (see R5) |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |
| send_ok | output | 1 | Send-permit handshake to the peer, low while sending |

## Verification
The bench goes after the following corner cases.
- **Masking of unused bits.** A 5-bit character is sent with ones only in the unused upper bits. A parity unit that counted those bits would send the wrong parity bit.
- **One and a half stop bits.** A baud tick is sent during the final half bit. A design that timed the half bit from baud ticks would end the frame early, and `busy` would drop before the half-baud tick.
- **Mid-frame interference.** A new load, changed configuration and a stray half-baud tick all arrive in the middle of a frame. A design that let any of them through would corrupt the later bits or shorten the frame.
- **Held start bit.** The start bit is held for several cycles with no baud tick. A design that left START on its own would shift the whole frame by one bit.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2,
        ST_STOPH
    } tx_state_t;

    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_EVEN  = 3'd1;
    localparam logic [2:0] PAR_ODD   = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd3;
    localparam logic [2:0] PAR_SPACE = 3'd4;

    localparam logic [1:0] STOP_ONE  = 2'd0;
    localparam logic [1:0] STOP_HALF = 2'd1;

endpackage

// File: rtl/sftx_parity.sv
module sftx_parity #(
    parameter int DATA_MIN = 5,
    parameter int DATA_MAX = 8,
    parameter int LEN_W    = 2
) (
    input  logic [DATA_MAX-1:0] data,
    input  logic [LEN_W-1:0]    len_sel,
    input  logic [2:0]          mode,
    output logic                par_bit,
    output logic                par_en
);
    import sftx_pkg::*;

    logic [DATA_MAX-1:0] used;

    // Only bits that are actually sent take part in the parity count
    for (genvar i = 0; i < DATA_MAX; i++) begin : g_mask
        if (i < DATA_MIN) begin : g_always
            assign used[i] = data[i];
        end else begin : g_cond
            assign used[i] = data[i] & (int'(len_sel) >= (i - DATA_MIN + 1));
        end
    end

    always_comb begin
        par_bit = 1'b0;
        par_en  = 1'b1;
        unique case (mode)
            PAR_EVEN:  par_bit = ^used;
            PAR_ODD:   par_bit = ~(^used);
            PAR_MARK:  par_bit = 1'b1;
            PAR_SPACE: par_bit = 1'b0;
            default:   par_en  = 1'b0;
        endcase
    end

endmodule

// File: rtl/sftx_fsm.sv
module sftx_fsm #(
    parameter int DATA_MIN = 5,
    parameter int DATA_MAX = 8,
    parameter int LEN_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_MAX-1:0] din,
    input  logic                load,
    input  logic                baud_tick,
    input  logic                half_tick,
    input  logic [LEN_W-1:0]    len_sel,
    input  logic [1:0]          stop_sel,
    input  logic                par_bit,
    input  logic                par_en,
    output logic                txd,
    output logic                busy,
    output logic                send_ok
);
    import sftx_pkg::*;

    localparam int CNT_W = $clog2(DATA_MAX);

    tx_state_t           state;
    logic [DATA_MAX-1:0] shreg;
    logic [CNT_W-1:0]    cnt;
    logic [LEN_W-1:0]    len_q;
    logic [1:0]          stop_q;
    logic                par_bit_q;
    logic                par_en_q;
    logic [CNT_W-1:0]    last_idx;
    logic                in_stop;

    assign last_idx = CNT_W'(DATA_MIN - 1) + CNT_W'(len_q);

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '1;
            cnt       <= '0;
            len_q     <= '0;
            stop_q    <= STOP_ONE;
            par_bit_q <= 1'b0;
            par_en_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (load) begin
                    state     <= ST_START;
                    shreg     <= din;
                    cnt       <= '0;
                    len_q     <= len_sel;
                    stop_q    <= stop_sel;
                    par_bit_q <= par_bit;
                    par_en_q  <= par_en;
                end
                ST_START: if (baud_tick) state <= ST_DATA;
                ST_DATA: if (baud_tick) begin
                    shreg <= shreg >> 1;
                    if (cnt == last_idx) begin
                        cnt   <= '0;
                        state <= par_en_q ? ST_PARITY : ST_STOP1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PARITY: if (baud_tick) state <= ST_STOP1;
                ST_STOP1: if (baud_tick) begin
                    if (stop_q == STOP_ONE)       state <= ST_IDLE;
                    else if (stop_q == STOP_HALF) state <= ST_STOPH;
                    else                          state <= ST_STOP2;
                end
                ST_STOP2: if (baud_tick) state <= ST_IDLE;
                ST_STOPH: if (half_tick) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        txd     = 1'b1;
        busy    = 1'b1;
        in_stop = 1'b0;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_bit_q;
            ST_STOP1, ST_STOP2, ST_STOPH: in_stop = 1'b1;
            default:   busy = 1'b0;
        endcase
        send_ok = ~busy;
    end

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    p_start_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && !baud_tick) |=> state == ST_START);

    p_load_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load && !baud_tick && !half_tick) |=> $stable(txd));

    p_half_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOPH && !half_tick) |=> state == ST_STOPH);

    p_end_from_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(in_stop));

    p_stop_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_stop |-> txd);

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
    parameter int DATA_MIN = 5,
    parameter int DATA_MAX = 8,
    parameter int LEN_W    = $clog2(DATA_MAX - DATA_MIN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_MAX-1:0] din,
    input  logic                load,
    input  logic                baud_tick,
    input  logic                half_tick,
    input  logic [LEN_W-1:0]    len_sel,
    input  logic [2:0]          par_mode,
    input  logic [1:0]          stop_sel,
    output logic                txd,
    output logic                busy,
    output logic                send_ok
);

    logic par_bit;
    logic par_en;

    sftx_parity #(
        .DATA_MIN (DATA_MIN),
        .DATA_MAX (DATA_MAX),
        .LEN_W    (LEN_W)
    ) u_parity (
        .data    (din),
        .len_sel (len_sel),
        .mode    (par_mode),
        .par_bit (par_bit),
        .par_en  (par_en)
    );

    sftx_fsm #(
        .DATA_MIN (DATA_MIN),
        .DATA_MAX (DATA_MAX),
        .LEN_W    (LEN_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .load      (load),
        .baud_tick (baud_tick),
        .half_tick (half_tick),
        .len_sel   (len_sel),
        .stop_sel  (stop_sel),
        .par_bit   (par_bit),
        .par_en    (par_en),
        .txd       (txd),
        .busy      (busy),
        .send_ok   (send_ok)
    );

endmodule

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic       load = 1'b0;
    logic       baud_tick = 1'b0;
    logic       half_tick = 1'b0;
    logic [1:0] len_sel = 2'd0;
    logic [2:0] par_mode = 3'd0;
    logic [1:0] stop_sel = 2'd0;
    logic       txd;
    logic       busy;
    logic       send_ok;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .din(din), .load(load),
        .baud_tick(baud_tick), .half_tick(half_tick),
        .len_sel(len_sel), .par_mode(par_mode), .stop_sel(stop_sel),
        .txd(txd), .busy(busy), .send_ok(send_ok)
    );

    // {data, len_sel, par_mode, stop_sel}
    localparam logic [14:0] VEC [8] = '{
        {8'h55, 2'd3, 3'd0, 2'd0},
        {8'hB3, 2'd3, 3'd1, 2'd2},
        {8'hB3, 2'd3, 3'd2, 2'd1},
        {8'h1F, 2'd0, 3'd1, 2'd1},
        {8'hE0, 2'd0, 3'd2, 2'd0},
        {8'h6A, 2'd1, 3'd3, 2'd2},
        {8'h6A, 2'd2, 3'd4, 2'd3},
        {8'h81, 2'd3, 3'd6, 2'd0}
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic pulse_baud();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
    endtask

    task automatic pulse_half();
        @(negedge clk) half_tick = 1'b1;
        @(negedge clk) half_tick = 1'b0;
    endtask

    function automatic logic has_par(input logic [2:0] p);
        return (p >= 3'd1 && p <= 3'd4);
    endfunction

    function automatic logic exp_bit(input logic [7:0] d, input int len,
                                     input logic [2:0] p, input int k);
        int ones = 0;
        if (k == 0) return 1'b0;
        if (k <= len) return d[k-1];
        for (int i = 0; i < len; i++) ones += int'(d[i]);
        case (p)
            3'd1: return (ones % 2) == 1;
            3'd2: return (ones % 2) == 0;
            3'd3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_frame(input logic [7:0] d, input logic [1:0] ls,
                             input logic [2:0] p, input logic [1:0] s,
                             input bit disturb);
        int len = int'(ls) + 5;
        int n = 1 + len + (has_par(p) ? 1 : 0);
        @(negedge clk);
        din = d; len_sel = ls; par_mode = p; stop_sel = s; load = 1'b1;
        @(negedge clk) load = 1'b0;
        chk("R2 busy after load", busy, 1'b1);
        chk("R7 send_ok low after load", send_ok, 1'b0);
        for (int k = 0; k < n; k++) begin
            chk($sformatf("R3/R4 bit %0d of %02h", k, d), txd, exp_bit(d, len, p, k));
            if (disturb && k == 2) begin
                // R6/R9/R8: new load, new config, stray half tick mid-frame
                @(negedge clk);
                din = ~d; len_sel = 2'd0; par_mode = 3'd3; stop_sel = 2'd0;
                load = 1'b1; half_tick = 1'b1;
                @(negedge clk) load = 1'b0; half_tick = 1'b0;
                chk("R6/R8 txd unchanged by load and half tick", txd, exp_bit(d, len, p, k));
            end
            pulse_baud();
        end
        chk("R5 first stop high", txd, 1'b1);
        chk("R7 busy in stop", busy, 1'b1);
        pulse_baud();
        if (s == 2'd1) begin
            chk("R5 half stop still busy", busy, 1'b1);
            pulse_baud();
            chk("R5/R8 baud ignored in half stop", busy, 1'b1);
            pulse_half();
        end else if (s != 2'd0) begin
            chk("R5 second stop busy", busy, 1'b1);
            chk("R5 second stop high", txd, 1'b1);
            pulse_baud();
        end
        chk("R7 busy low after stop", busy, 1'b0);
        chk("R1 send_ok after frame", send_ok, 1'b1);
        chk("R1 idle line high", txd, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset txd", txd, 1'b1);
        chk("R1 reset busy", busy, 1'b0);
        chk("R1 reset send_ok", send_ok, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        pulse_half();
        chk("R8 half tick idle", busy, 1'b0);

        for (int v = 0; v < 8; v++) begin
            run_frame(VEC[v][14:7], VEC[v][6:5], VEC[v][4:2], VEC[v][1:0], 1'b0);
        end

        // R2: start bit held with no baud tick
        @(negedge clk);
        din = 8'h0F; len_sel = 2'd3; par_mode = 3'd0; stop_sel = 2'd0; load = 1'b1;
        @(negedge clk) load = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 start bit held", txd, 1'b0);
        chk("R2 still busy", busy, 1'b1);
        for (int k = 0; k < 10; k++) pulse_baud();
        chk("R7 held frame ended", busy, 1'b0);

        // R6/R9: interference during a frame
        run_frame(8'h0F, 2'd3, 3'd1, 2'd1, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule